// File: doc/BRIEF.md
# Pin bank with interrupt detection

An eight-pin general-purpose I/O block on a simple register bus (write strobe, read strobe, byte address, 8-bit data). Each pin can be turned into an output under software control, and its pin value is reached through an address-masked data window. Because eight address bits act as a pin mask, software can read or change any subset of pins in one access without a read-modify-write sequence.

Every pin also feeds an interrupt detector. The input goes through a two-flop synchroniser. Software then picks level or edge sensing, the active polarity, or sensing on both edges. The block keeps a raw status vector and a masked status vector, clears latched edges through a write-one-to-clear register, and drives one combined interrupt line.

Top module: `pinbank_io`

## Requirements
- R1: Writing the direction register (byte address 0x400) sets the pin output-enable vector `pin_oe` to the written byte from the next clock edge. Bit value 1 makes that pin an output.
- R2: A write in the data window (addresses 0x000 to 0x3FC, address bits [11:10] = 0) updates the output latch `pin_out` only in the pins whose bit in address[9:2] is 1. All other pins keep their value.
- R3: A read in the data window returns 0 in every bit whose address[9:2] mask bit is 0. In a masked bit it returns the output latch if that pin's direction bit is 1, and the synchronised input if the bit is 0.
- R4: An input change becomes visible in data reads after two rising clock edges and not after one.
- R5: When the sense bit of a pin is 1 (register 0x404), its raw status follows the synchronised input: active-high if its event bit (0x40C) is 1, active-low if 0. Writing the clear register does not change it.
- R6: When the sense bit is 0 and the both-edges bit (0x408) is 0, a rising edge (event bit 1) or a falling edge (event bit 0) of the synchronised input sets a latched raw status bit, which stays set until cleared. The opposite edge does nothing.
- R7: When the sense bit is 0 and the both-edges bit is 1, rising and falling edges both set the latched status, whatever the event bit is.
- R8: Raw status reads at 0x414, and masked status reads at 0x418 as raw AND enable (0x410). `irq_out` is 1 exactly when any masked status bit is 1.
- R9: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge status, and bits written 0 keep theirs. If an edge is detected on the same clock edge as the clear, the status stays set.
- R10: After reset all registers, the output latch and the latched status are 0, the enable register reads 0 and `irq_out` is low.
- R11: Reads of 0x41C, of undefined offsets and of addresses whose bits [1:0] are not zero return 0, and `bus_rdata` is 0 when `bus_rd` is low. Writes to 0x414, 0x418, undefined offsets or addresses whose bits [1:0] are not zero change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data returned in the same cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Output latch value toward the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two functions can act in the same cycle: a new edge on a pin and a software clear of that pin's latched status. The bench changes the pin and then delays the clear write so that it arrives on exactly the third clock edge after the change, which is the edge where the detector sees the transition. It judges the outcome by reading raw status afterwards and by watching `irq_out`: the bit must still be set. A reference model that runs every cycle compares all outputs along the way.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int PINS = 8;

    typedef logic [PINS-1:0] pinvec_t;

    // Word index inside the control page; the order fixes the offsets.
    typedef enum logic [2:0] {
        REG_DIR   = 3'd0,
        REG_SENSE = 3'd1,
        REG_BOTH  = 3'd2,
        REG_EVT   = 3'd3,
        REG_IEN   = 3'd4,
        REG_RAW   = 3'd5,
        REG_MIS   = 3'd6,
        REG_CLR   = 3'd7
    } ctl_sel_t;

    typedef struct packed {
        pinvec_t dir;
        pinvec_t sense;
        pinvec_t both;
        pinvec_t evt;
        pinvec_t ien;
    } ctl_regs_t;

    function automatic pinvec_t merge_masked(pinvec_t old_v, pinvec_t new_v, pinvec_t m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic sense,
    input  logic both,
    input  logic evt,
    input  logic clr,
    output logic raw
);
    logic prev, held;
    logic rise, fall, hit;

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
    assign hit  = both ? (rise | fall) : (evt ? rise : fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            held <= 1'b0;
        end else begin
            prev <= lvl;
            if (sense)    held <= 1'b0;
            else if (hit) held <= 1'b1;
            else if (clr) held <= 1'b0;
        end
    end

    assign raw = sense ? (lvl ~^ evt) : held;

    // R6: a latched edge stays until a clear arrives
    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (held && !sense && !clr) |=> held);

    // R9: detection on the clearing edge keeps the bit set
    assert_hit_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!sense && hit) |=> held);

    // R9: a clear with no new edge drops the bit
    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (!sense && clr && !hit) |=> !held);
endmodule

// File: rtl/pinbank_io.sv
module pinbank_io
    import pinbank_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_out
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + PINS - 1;
    localparam int PAGE_W  = ADDR_W - MASK_HI - 1;

    // ---------------- address decode ----------------
    logic              aligned, hit_data, hit_ctl;
    logic [PAGE_W-1:0] page;
    pinvec_t           mask;
    ctl_sel_t          sel;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign page     = bus_addr[ADDR_W-1:MASK_HI+1];
    assign mask     = bus_addr[MASK_HI:MASK_LO];
    assign sel      = ctl_sel_t'(bus_addr[4:2]);
    assign hit_data = aligned && (page == '0);
    assign hit_ctl  = aligned && (page == PAGE_W'(1)) && (bus_addr[MASK_HI:5] == '0);

    // ---------------- register file ----------------
    ctl_regs_t regs;
    pinvec_t   out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            out_q <= '0;
        end else if (bus_wr) begin
            if (hit_data) begin
                out_q <= merge_masked(out_q, bus_wdata, mask);
            end else if (hit_ctl) begin
                case (sel)
                    REG_DIR:   regs.dir   <= bus_wdata;
                    REG_SENSE: regs.sense <= bus_wdata;
                    REG_BOTH:  regs.both  <= bus_wdata;
                    REG_EVT:   regs.evt   <= bus_wdata;
                    REG_IEN:   regs.ien   <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    pinvec_t clr_vec;
    assign clr_vec = (bus_wr && hit_ctl && sel == REG_CLR) ? bus_wdata : '0;

    // ---------------- input path ----------------
    pinvec_t lvl;

    pinbank_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    pinvec_t raw, mis;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        pinbank_detect u_det (
            .clk   (clk),
            .rst   (rst),
            .lvl   (lvl[g]),
            .sense (regs.sense[g]),
            .both  (regs.both[g]),
            .evt   (regs.evt[g]),
            .clr   (clr_vec[g]),
            .raw   (raw[g])
        );
    end

    assign mis     = raw & regs.ien;
    assign irq_out = |mis;

    // ---------------- outputs and read mux ----------------
    pinvec_t pin_view;
    assign pin_view = (out_q & regs.dir) | (lvl & ~regs.dir);
    assign pin_out  = out_q;
    assign pin_oe   = regs.dir;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_data) begin
                bus_rdata = pin_view & mask;
            end else if (hit_ctl) begin
                case (sel)
                    REG_DIR:   bus_rdata = regs.dir;
                    REG_SENSE: bus_rdata = regs.sense;
                    REG_BOTH:  bus_rdata = regs.both;
                    REG_EVT:   bus_rdata = regs.evt;
                    REG_IEN:   bus_rdata = regs.ien;
                    REG_RAW:   bus_rdata = raw;
                    REG_MIS:   bus_rdata = mis;
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    // R1: the written direction byte appears on the enables
    assert_oe_follows_dir_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_ctl && sel == REG_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R2: pins outside the address mask keep their output value
    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_data) |=>
        (((pin_out ^ $past(pin_out)) & ~$past(bus_addr[MASK_HI:MASK_LO])) == '0));

    // R10: no interrupt can leave while every enable is off
    assert_quiet_when_disabled_R10: assert property (@(posedge clk) disable iff (rst)
        (regs.ien == '0) |-> !irq_out);
endmodule

// File: tb/pinbank_io_test.sv
module pinbank_io_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq_out;

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R10";
    bit    started = 1'b0;
    bit    done = 1'b0;

    always #4 clk = ~clk;   // 8 ns period

    pinbank_io uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_dir = '0, m_out = '0, m_sense = '0, m_both = '0;
    logic [7:0] m_evt = '0, m_ien = '0, m_lat = '0;
    logic [7:0] hist[$];   // [0] previous sample, [1] current synced, [2] first stage

    initial hist = '{8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] model_raw();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_sense[i] ? (hist[1][i] == m_evt[i]) : m_lat[i];
        return r;
    endfunction

    function automatic logic [7:0] model_rdata(input logic rd, input logic [11:0] a);
        if (!rd || a[1:0] != 2'b00) return 8'h00;
        if (a < 12'h400)
            return ((m_out & m_dir) | (hist[1] & ~m_dir)) & a[9:2];
        case (a)
            12'h400: return m_dir;
            12'h404: return m_sense;
            12'h408: return m_both;
            12'h40C: return m_evt;
            12'h410: return m_ien;
            12'h414: return model_raw();
            12'h418: return model_raw() & m_ien;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dir = '0; m_out = '0; m_sense = '0; m_both = '0;
            m_evt = '0; m_ien = '0; m_lat = '0;
            hist = '{8'h00, 8'h00, 8'h00};
        end else begin
            for (int i = 0; i < 8; i++) begin
                logic s, p, hit;
                s = hist[1][i];
                p = hist[0][i];
                if (m_both[i])      hit = (s != p);
                else if (m_evt[i])  hit = s && !p;
                else                hit = !s && p;
                if (m_sense[i])     m_lat[i] = 1'b0;
                else if (hit)       m_lat[i] = 1'b1;
                else if (bus_wr && bus_addr == 12'h41C && bus_wdata[i]) m_lat[i] = 1'b0;
            end
            if (bus_wr && bus_addr[1:0] == 2'b00) begin
                if (bus_addr < 12'h400)
                    m_out = (m_out & ~bus_addr[9:2]) | (bus_wdata & bus_addr[9:2]);
                else case (bus_addr)
                    12'h400: m_dir   = bus_wdata;
                    12'h404: m_sense = bus_wdata;
                    12'h408: m_both  = bus_wdata;
                    12'h40C: m_evt   = bus_wdata;
                    12'h410: m_ien   = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_back(pin_in);
            void'(hist.pop_front());
        end
        started = 1'b1;
    end

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1", "pin_oe", pin_oe, m_dir);
            chk("R2", "pin_out", pin_out, m_out);
            chk("R8", "irq_out", {7'b0, irq_out}, {7'b0, |(model_raw() & m_ien)});
            chk(cur_req, "bus_rdata", bus_rdata, model_rdata(bus_rd, bus_addr));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        #2 chk(req, "read", bus_rdata, exp);
        @(negedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic setpins(input logic [7:0] v);
        @(negedge clk); #1;
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R10: reset state
        cur_req = "R10";
        idle(2);
        chk("R10", "irq after reset", {7'b0, irq_out}, 8'h00);
        chk("R10", "pin_oe after reset", pin_oe, 8'h00);
        rd_expect(12'h410, 8'h00, "R10");
        rd_expect(12'h414, 8'h00, "R10");

        // R1: direction
        cur_req = "R1";
        wr(12'h400, 8'h0F);
        chk("R1", "pin_oe", pin_oe, 8'h0F);
        rd_expect(12'h400, 8'h0F, "R1");

        // R2: masked writes
        cur_req = "R2";
        wr(12'h00C, 8'hFF);
        chk("R2", "mask 03", pin_out, 8'h03);
        wr(12'h3FC, 8'hA5);
        wr(12'h0C0, 8'h00);
        chk("R2", "mask 30", pin_out, 8'h85);

        // R3: masked reads
        cur_req = "R3";
        rd_expect(12'h03C, 8'h05, "R3");
        setpins(8'hF0);
        idle(4);
        rd_expect(12'h3FC, 8'hF5, "R3");
        rd_expect(12'h0C0, 8'h30, "R3");

        // R4: two-edge synchroniser latency
        cur_req = "R4";
        setpins(8'h00);
        rd_expect(12'h3FC, 8'hF5, "R4");
        rd_expect(12'h3FC, 8'h05, "R4");

        // configure: pin3 level low, pin4 rising, pin5 falling, pin6 both, pin7 level high
        cur_req = "R5";
        wr(12'h400, 8'h07);
        wr(12'h404, 8'h88);
        wr(12'h40C, 8'h90);
        wr(12'h408, 8'h40);
        idle(3);
        wr(12'h41C, 8'hFF);
        rd_expect(12'h414, 8'h08, "R5");

        // R8: masking and combined line
        cur_req = "R8";
        rd_expect(12'h418, 8'h00, "R8");
        chk("R8", "irq masked off", {7'b0, irq_out}, 8'h00);
        wr(12'h410, 8'hF8);
        chk("R8", "irq enabled", {7'b0, irq_out}, 8'h01);
        rd_expect(12'h418, 8'h08, "R8");

        // R5: level sensing, not clearable
        cur_req = "R5";
        setpins(8'h08);
        idle(4);
        rd_expect(12'h414, 8'h00, "R5");
        setpins(8'h88);
        idle(4);
        rd_expect(12'h414, 8'h80, "R5");
        wr(12'h41C, 8'hFF);
        rd_expect(12'h414, 8'h80, "R5");
        setpins(8'h08);
        idle(4);
        rd_expect(12'h414, 8'h00, "R5");

        // R6: single-polarity edges
        cur_req = "R6";
        setpins(8'h18);
        idle(4);
        rd_expect(12'h414, 8'h10, "R6");
        setpins(8'h08);
        idle(4);
        rd_expect(12'h414, 8'h10, "R6");
        setpins(8'h28);
        idle(4);
        rd_expect(12'h414, 8'h10, "R6");
        setpins(8'h08);
        idle(4);
        rd_expect(12'h414, 8'h30, "R6");

        // R9: selective clear
        cur_req = "R9";
        wr(12'h41C, 8'h10);
        rd_expect(12'h414, 8'h20, "R9");
        wr(12'h41C, 8'h20);
        rd_expect(12'h414, 8'h00, "R9");

        // R7: both edges
        cur_req = "R7";
        setpins(8'h48);
        idle(4);
        rd_expect(12'h414, 8'h40, "R7");
        wr(12'h41C, 8'h40);
        setpins(8'h08);
        idle(4);
        rd_expect(12'h414, 8'h40, "R7");
        wr(12'h41C, 8'h40);
        rd_expect(12'h414, 8'h00, "R7");

        // R9: edge and clear on the same clock edge
        cur_req = "R9";
        setpins(8'h48);
        @(negedge clk);
        wr(12'h41C, 8'h40);
        idle(2);
        rd_expect(12'h414, 8'h40, "R9");
        chk("R9", "irq kept", {7'b0, irq_out}, 8'h01);
        wr(12'h41C, 8'h40);
        rd_expect(12'h414, 8'h00, "R9");

        // R11: ignored accesses
        cur_req = "R11";
        rd_expect(12'h41C, 8'h00, "R11");
        rd_expect(12'h420, 8'h00, "R11");
        rd_expect(12'h800, 8'h00, "R11");
        rd_expect(12'h401, 8'h00, "R11");
        wr(12'h414, 8'hFF);
        wr(12'h418, 8'hFF);
        rd_expect(12'h414, 8'h00, "R11");
        wr(12'h401, 8'hFF);
        wr(12'h3FD, 8'h00);
        rd_expect(12'h400, 8'h07, "R11");
        chk("R11", "pin_oe unchanged", pin_oe, 8'h07);
        chk("R11", "pin_out unchanged", pin_out, 8'h85);
        idle(2);

        finish_run();
    end
endmodule